// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block is the control logic that sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), with pipeline registers between each pair of stages. Each cycle it looks at the register numbers held in the pipeline registers. It then picks where each execute-stage operand comes from: the register file, the execute/memory register, or the memory/writeback register. It also decides whether the front of the pipeline must pause for a load result, or whether the younger instructions must be discarded because a branch taken in the memory stage has redirected fetch.

The unit is purely combinational: all outputs follow the current inputs within the same cycle, and the datapath registers act on them at the next clock edge. A load whose result is needed by the instruction right behind it cannot be covered by forwarding. For that case the unit holds the program counter and the fetch/decode register for one cycle and turns the execute-stage entry into a bubble. The register file is assumed to write before it reads within a cycle, so the unit has no path from writeback to decode. The block moves no data of its own, so it has no valid/ready handshake. Every pin is a plain level control.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the execute/memory register writes (`exmem_wr_en`=1) a nonzero destination equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the memory/writeback register writes (`memwb_wr_en`=1) a nonzero destination equal to an execute-stage source, that operand's select is 2'b01.
- R3: If both the execute/memory and the memory/writeback registers match the same source, the select is 2'b10: the younger result wins.
- R4: Register 0 is never forwarded, and a destination whose write enable is low is never forwarded. In both cases the select is 2'b00 (register file).
- R5: The two operand selects are computed independently, and neither ever takes the value 2'b11.
- R6: When `idex_mem_read`=1 and `idex_dst` is nonzero and equal to either decode-stage source, `hold_pc_ifid` and `bubble_idex` are both 1.
- R7: With no load in the execute stage, with a load to register 0, or with no decode-stage source matching, `hold_pc_ifid` and `bubble_idex` are 0.
- R8: When `mem_branch_taken`=1, `flush_young` is 1 and both `hold_pc_ifid` and `bubble_idex` are 0, even if a load-use hazard is also present. Otherwise `flush_young` is 0.
- R9: Destinations in the execute/memory and memory/writeback registers never cause a stall. A later writer is covered by forwarding or by the write-then-read register file.
- R10: Every output is a combinational function of the current inputs, valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_src_a | input | 5 | First source register of the instruction in execute |
| idex_src_b | input | 5 | Second source register of the instruction in execute |
| ifid_src_a | input | 5 | First source register of the instruction in decode |
| ifid_src_b | input | 5 | Second source register of the instruction in decode |
| idex_dst | input | 5 | Destination register of the instruction in execute |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| exmem_dst | input | 5 | Destination register held in execute/memory |
| exmem_wr_en | input | 1 | Instruction in execute/memory writes a register |
| memwb_dst | input | 5 | Destination register held in memory/writeback |
| memwb_wr_en | input | 1 | Instruction in memory/writeback writes a register |
| mem_branch_taken | input | 1 | Branch in the memory stage is taken |
| fwd_sel_a | output | 2 | First operand source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_sel_b | output | 2 | Second operand source, same encoding |
| hold_pc_ifid | output | 1 | Keep the PC and the fetch/decode register unchanged this cycle |
| bubble_idex | output | 1 | Load a bubble into the decode/execute register |
| flush_young | output | 1 | Replace fetch/decode, decode/execute and execute/memory contents with bubbles |

## Verification
Every result of this block is due zero cycles after its stimulus: the selects, hold, bubble and flush settle combinationally from the same input vector. The bench therefore applies each vector on the rising edge and samples all five outputs on the following falling edge, before the next vector is driven. Random vectors draw register numbers from a small range so that matches, register-0 cases and simultaneous forward-and-stall cases occur often. Directed vectors pin down priority and the branch-over-stall case.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opnd_src_e;

endpackage

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exmem_dst,
  input  logic          exmem_we,
  input  logic [AW-1:0] memwb_dst,
  input  logic          memwb_we,
  output logic [1:0]    sel
);
  import hz_pkg::*;

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic      hit_exmem;
  logic      hit_memwb;
  opnd_src_e choice;

  assign hit_exmem = exmem_we && (exmem_dst != ZERO_REG) && (exmem_dst == src);
  assign hit_memwb = memwb_we && (memwb_dst != ZERO_REG) && (memwb_dst == src);

  // Younger producer (execute/memory) has priority.
  always_comb begin
    if (hit_exmem)      choice = SRC_EXMEM;
    else if (hit_memwb) choice = SRC_MEMWB;
    else                choice = SRC_REGFILE;
  end

  assign sel = choice;

  always_comb begin
    assert_sel_legal_R5: assert (sel != 2'b11)
      else $error("R5: illegal select %b", sel);
    assert_zero_src_R4: assert (!(src == ZERO_REG && sel != 2'b00))
      else $error("R4: register 0 forwarded, sel %b", sel);
    assert_exmem_wins_R3: assert (!(hit_exmem && hit_memwb) || sel == 2'b10)
      else $error("R3: priority lost, sel %b", sel);
  end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][AW-1:0] dec_src,
  input  logic [AW-1:0]              load_dst,
  input  logic                       load_in_ex,
  output logic                       hazard
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] src_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = (dec_src[i] == load_dst);
  end

  assign hazard = load_in_ex && (load_dst != ZERO_REG) && (|src_hit);

  always_comb begin
    assert_no_load_no_hz_R7: assert (load_in_ex || !hazard)
      else $error("R7: stall without a load");
  end

endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl (
  input  logic load_hazard,
  input  logic branch_taken,
  output logic hold,
  output logic bubble,
  output logic flush
);
  // A taken branch discards the stalled instructions anyway, so it wins.
  always_comb begin
    flush  = branch_taken;
    hold   = load_hazard && !branch_taken;
    bubble = load_hazard && !branch_taken;
  end

  always_comb begin
    assert_flush_excl_R8: assert (!(flush && (hold || bubble)))
      else $error("R8: stall during flush");
    assert_hold_bubble_R6: assert (hold == bubble)
      else $error("R6: hold and bubble disagree");
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] idex_src_a,
  input  logic [AW-1:0] idex_src_b,
  input  logic [AW-1:0] ifid_src_a,
  input  logic [AW-1:0] ifid_src_b,
  input  logic [AW-1:0] idex_dst,
  input  logic          idex_mem_read,
  input  logic [AW-1:0] exmem_dst,
  input  logic          exmem_wr_en,
  input  logic [AW-1:0] memwb_dst,
  input  logic          memwb_wr_en,
  input  logic          mem_branch_taken,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          hold_pc_ifid,
  output logic          bubble_idex,
  output logic          flush_young
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][AW-1:0] ex_src;
  logic [NUM_SRC-1:0][AW-1:0] dec_src;
  logic [NUM_SRC-1:0][1:0]    sel;
  logic                       load_hazard;

  assign ex_src  = {idex_src_b, idex_src_a};
  assign dec_src = {ifid_src_b, ifid_src_a};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
    fwd_select #(.AW(AW)) u_fwd (
      .src       (ex_src[i]),
      .exmem_dst (exmem_dst),
      .exmem_we  (exmem_wr_en),
      .memwb_dst (memwb_dst),
      .memwb_we  (memwb_wr_en),
      .sel       (sel[i])
    );
  end

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];

  load_use_detect #(.AW(AW), .NUM_SRC(NUM_SRC)) u_lud (
    .dec_src    (dec_src),
    .load_dst   (idex_dst),
    .load_in_ex (idex_mem_read),
    .hazard     (load_hazard)
  );

  flow_ctrl u_flow (
    .load_hazard  (load_hazard),
    .branch_taken (mem_branch_taken),
    .hold         (hold_pc_ifid),
    .bubble       (bubble_idex),
    .flush        (flush_young)
  );

  always_comb begin
    assert_we_gate_R4: assert (exmem_wr_en || memwb_wr_en ||
                               (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00))
      else $error("R4: forward with no writer");
  end

endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] idex_src_a, idex_src_b, ifid_src_a, ifid_src_b, idex_dst;
  logic [AW-1:0] exmem_dst, memwb_dst;
  logic idex_mem_read, exmem_wr_en, memwb_wr_en, mem_branch_taken;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic hold_pc_ifid, bubble_idex, flush_young;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  pipe_hazard_ctrl #(.AW(AW)) u_pipe_hazard_ctrl (
    .idex_src_a(idex_src_a), .idex_src_b(idex_src_b),
    .ifid_src_a(ifid_src_a), .ifid_src_b(ifid_src_b),
    .idex_dst(idex_dst), .idex_mem_read(idex_mem_read),
    .exmem_dst(exmem_dst), .exmem_wr_en(exmem_wr_en),
    .memwb_dst(memwb_dst), .memwb_wr_en(memwb_wr_en),
    .mem_branch_taken(mem_branch_taken),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .hold_pc_ifid(hold_pc_ifid), .bubble_idex(bubble_idex),
    .flush_young(flush_young)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] s);
    if (exmem_wr_en && exmem_dst != 0 && exmem_dst == s) return 2'b10;
    if (memwb_wr_en && memwb_dst != 0 && memwb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    logic hz;
    hz = idex_mem_read && idex_dst != 0 &&
         (idex_dst == ifid_src_a || idex_dst == ifid_src_b);
    return hz && !mem_branch_taken;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [AW-1:0] xa, logic [AW-1:0] xb, logic [AW-1:0] da,
                       logic [AW-1:0] db, logic [AW-1:0] ld, logic lr,
                       logic [AW-1:0] md, logic mw, logic [AW-1:0] wd, logic ww,
                       logic br);
    @(posedge clk);
    idex_src_a = xa; idex_src_b = xb; ifid_src_a = da; ifid_src_b = db;
    idex_dst = ld; idex_mem_read = lr; exmem_dst = md; exmem_wr_en = mw;
    memwb_dst = wd; memwb_wr_en = ww; mem_branch_taken = br;
    @(negedge clk); // R10: same-cycle result
  endtask

  task automatic check_all(string tag);
    chk({tag, " R1/R2/R3/R4 sel_a"}, {2'b0, fwd_sel_a}, {2'b0, exp_sel(idex_src_a)});
    chk({tag, " R5 sel_b"},          {2'b0, fwd_sel_b}, {2'b0, exp_sel(idex_src_b)});
    chk({tag, " R6/R7 hold"},   {3'b0, hold_pc_ifid}, {3'b0, exp_stall()});
    chk({tag, " R6/R7 bubble"}, {3'b0, bubble_idex},  {3'b0, exp_stall()});
    chk({tag, " R8 flush"},     {3'b0, flush_young},  {3'b0, mem_branch_taken});
  endtask

  initial begin
    void'($urandom(32'd1234));
    // Idle state: nothing forwarded, no stall, no flush
    apply(0,0,0,0,0,0,0,0,0,0,0);
    chk("R10 idle sel_a", {2'b0, fwd_sel_a}, 4'h0);
    chk("R10 idle ctrl", {1'b0, hold_pc_ifid, bubble_idex, flush_young}, 4'h0);
    // R1 forward from EX/MEM
    apply(3,4,0,0,0,0,3,1,0,0,0);
    chk("R1 exmem fwd", {2'b0, fwd_sel_a}, 4'h2);
    // R2 forward from MEM/WB on operand B
    apply(3,4,0,0,0,0,0,0,4,1,0);
    chk("R2 memwb fwd", {2'b0, fwd_sel_b}, 4'h1);
    // R3 both match
    apply(6,6,0,0,0,0,6,1,6,1,0);
    chk("R3 priority a", {2'b0, fwd_sel_a}, 4'h2);
    chk("R3 priority b", {2'b0, fwd_sel_b}, 4'h2);
    // R4 register 0 and disabled writes
    apply(0,0,0,0,0,0,0,1,0,1,0);
    chk("R4 zero reg", {fwd_sel_a, fwd_sel_b}, 4'h0);
    apply(7,7,0,0,0,0,7,0,7,0,0);
    chk("R4 we low", {fwd_sel_a, fwd_sel_b}, 4'h0);
    // R4 EX/MEM to reg0 disabled falls back to MEM/WB
    apply(0,9,0,0,0,0,9,0,9,1,0);
    chk("R4 fallback", {fwd_sel_a, fwd_sel_b}, 4'h1);
    // R6 load-use on operand B
    apply(0,0,1,5,5,1,0,0,0,0,0);
    chk("R6 load-use", {2'b0, hold_pc_ifid, bubble_idex}, 4'h3);
    // R7 load to reg 0, and non-load match
    apply(0,0,0,0,0,1,0,0,0,0,0);
    chk("R7 load r0", {2'b0, hold_pc_ifid, bubble_idex}, 4'h0);
    apply(0,0,5,5,5,0,0,0,0,0,0);
    chk("R7 not load", {2'b0, hold_pc_ifid, bubble_idex}, 4'h0);
    // R8 branch overrides load-use
    apply(0,0,5,0,5,1,0,0,0,0,1);
    chk("R8 branch wins", {1'b0, hold_pc_ifid, bubble_idex, flush_young}, 4'h1);
    // R9 later writers never stall
    apply(0,0,8,9,1,0,8,1,9,1,0);
    chk("R9 no stall from later", {2'b0, hold_pc_ifid, bubble_idex}, 4'h0);

    for (int i = 0; i < 600; i++) begin
      apply($urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
            $urandom_range(0,3), $urandom_range(0,3), 1'($urandom_range(0,1)),
            $urandom_range(0,3), 1'($urandom_range(0,1)), $urandom_range(0,3),
            1'($urandom_range(0,1)), 1'($urandom_range(0,7) == 0));
      check_all("rand");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule